// File: doc/BRIEF.md
# Multidrop Device Selection Engine

This block is the network layer of a single-wire slave. It sits between a byte and bit level link controller and the memory-command layer. After every bus reset it waits for one command byte. It then runs one of several selection procedures against a fixed 64-bit identity. The identity is an 8-bit family code, then a 48-bit serial number, then an 8-bit CRC that the block computes over the first 56 bits. When a procedure succeeds, the device is marked as the selected one and control passes to the memory layer. When a procedure fails, the block stays silent until the next bus reset.

The link controller tells the block about received bytes, received bits, finished transmit bits and bus resets. It also reports whether a reset had standard length. The block answers with one request at a time: it wants a command byte, it wants a bit, or it is offering a bit to send. It also drives a selected level, a single-cycle hand-off pulse and an overdrive speed level.

Top module: `rom_select_engine`

## Requirements
- R1: After reset and after every bus reset, only `rx_byte_req` is high among the requests. `selected` and `mem_go` are low.
- R2: Command 33h sends the 64 identity bits in this order: family code LSB first, then serial LSB first, then CRC LSB first. Each bit is held on `tx_bit` with `tx_bit_vld` high until `tx_bit_done`. The CRC uses x^8+x^5+x^4+1, is computed LSB first from a zero seed, and works as a reflected shift with feedback constant 8Ch. After the last bit the device is selected.
- R3: Command 55h receives 64 bits and compares each with the identity in the same order. A full match selects the device. The first differing bit ends all requests, and the device stays unselected until the next bus reset.
- R4: Command F0h runs three steps for each identity bit, in order: send the bit, send its complement, receive the master's bit. A differing master bit ends all requests. Completing all 64 bits selects the device.
- R5: Command CCh selects the device in the cycle after the byte arrives.
- R6: Command A5h selects the device only when the resume flag is set; otherwise the block goes silent. The flag is set by a completed 55h, 69h or F0h. It is cleared by 33h, CCh, 3Ch, any unknown code and any selection that fails. A bus reset does not change it.
- R7: Commands 3Ch (skip form) and 69h (match form) raise `overdrive` in the cycle after the byte. A bus reset with `bus_reset_std` high clears it. A bus reset with `bus_reset_std` low leaves it unchanged.
- R8: A bus reset in any state, including mid-transfer, takes priority over all other inputs in that cycle. It returns the block to waiting for a command byte and clears `selected`.
- R9: `mem_go` is a one-cycle pulse in exactly the cycle where `selected` rises.
- R10: Any other command code leaves the block silent and unselected until the next bus reset.
- R11: At most one of `tx_bit_vld`, `rx_bit_req` and `rx_byte_req` is high in any cycle. None is high while the device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | One-cycle strobe: a bus reset was seen |
| bus_reset_std | input | 1 | Qualifies bus_reset: the reset had standard-speed length |
| rx_byte_vld | input | 1 | Strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_bit_vld | input | 1 | Strobe: a received bit is on rx_bit |
| rx_bit | input | 1 | Received bit |
| tx_bit_done | input | 1 | Strobe: the offered bit has been sent |
| tx_bit_vld | output | 1 | A bit is offered for transmission |
| tx_bit | output | 1 | Bit value to send |
| rx_bit_req | output | 1 | Engine expects a bit from the master |
| rx_byte_req | output | 1 | Engine expects a command byte |
| selected | output | 1 | Device is the selected one |
| overdrive | output | 1 | Overdrive bus speed enabled |
| mem_go | output | 1 | One-cycle hand-off pulse to the memory layer |

## Verification
The assertions check on every cycle that the request outputs are mutually exclusive and silent while selected. They also check that a bus reset clears the selection and returns to byte wait, that overdrive follows the reset length, and that skip selects at once. Only the bench's scenarios can show that the identity bits come out in the right order with the right CRC. The same holds for the search complement steps, drop-out at a chosen bit, and the resume flag's history across several resets and failed selections.

// File: rtl/rom_select_pkg.sv
package rom_select_pkg;
   typedef enum logic [2:0] {
      ST_CMD, ST_READ, ST_MATCH, ST_SBIT, ST_SCMP, ST_SRX, ST_DONE, ST_DEAD
   } rse_state_t;

   localparam logic [7:0] CMD_READ     = 8'h33;
   localparam logic [7:0] CMD_MATCH    = 8'h55;
   localparam logic [7:0] CMD_SEARCH   = 8'hF0;
   localparam logic [7:0] CMD_SKIP     = 8'hCC;
   localparam logic [7:0] CMD_RESUME   = 8'hA5;
   localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
   localparam logic [7:0] CMD_OD_MATCH = 8'h69;
endpackage

// File: rtl/rom_id_crc.sv
module rom_id_crc #(
   parameter int DATA_W = 56,
   parameter int CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY_R = 8'h8C
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] chain [0:DATA_W];
   assign chain[0] = '0;
   for (genvar i = 0; i < DATA_W; i++) begin : g_step
      logic fb;
      assign fb = chain[i][0] ^ data[i];
      assign chain[i+1] = (chain[i] >> 1) ^ (fb ? POLY_R : '0);
   end
   assign crc = chain[DATA_W];
endmodule

// File: rtl/rom_bit_ptr.sv
module rom_bit_ptr #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (clr) idx <= '0;
      else if (inc) idx <= idx + 1'b1;
   end
   assign last = (idx == {IDX_W{1'b1}});
endmodule

// File: rtl/rom_select_engine.sv
module rom_select_engine
   import rom_select_pkg::*;
#(
   parameter int FAM_W  = 8,
   parameter int SER_W  = 48,
   parameter int CRC_W  = 8,
   parameter logic [FAM_W-1:0] FAMILY = 8'h2D,
   parameter logic [SER_W-1:0] SERIAL = 48'h00A1B2C3D4E5,
   parameter bit OD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_reset,
   input  logic       bus_reset_std,
   input  logic       rx_byte_vld,
   input  logic [7:0] rx_byte,
   input  logic       rx_bit_vld,
   input  logic       rx_bit,
   input  logic       tx_bit_done,
   output logic       tx_bit_vld,
   output logic       tx_bit,
   output logic       rx_bit_req,
   output logic       rx_byte_req,
   output logic       selected,
   output logic       overdrive,
   output logic       mem_go
);
   localparam int ID_W   = FAM_W + SER_W + CRC_W;
   localparam int BODY_W = FAM_W + SER_W;
   localparam int IDX_W  = $clog2(ID_W);

   if (ID_W != (1 << IDX_W)) begin : g_bad_len
      $error("identity length must be a power of two");
   end
   if (CRC_W != 8) begin : g_bad_crc
      $error("identity CRC must be 8 bits wide");
   end

   logic [CRC_W-1:0] id_crc;
   logic [ID_W-1:0]  id_vec;
   logic [IDX_W-1:0] idx;
   logic             idx_last;
   logic             idx_inc;
   logic             cur_bit;

   rom_id_crc #(.DATA_W(BODY_W), .CRC_W(CRC_W), .POLY_R(8'h8C)) u_crc (
      .data ({SERIAL, FAMILY}),
      .crc  (id_crc)
   );
   assign id_vec  = {id_crc, SERIAL, FAMILY};

   rom_bit_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bus_reset),
      .inc   (idx_inc),
      .idx   (idx),
      .last  (idx_last)
   );
   assign cur_bit = id_vec[idx];

   rse_state_t st_q, st_n;
   logic sel_set, rc_set, rc_clr, od_set;
   logic rc_q, sel_q, go_q;

   always_comb begin
      st_n    = st_q;
      idx_inc = 1'b0;
      sel_set = 1'b0;
      rc_set  = 1'b0;
      rc_clr  = 1'b0;
      od_set  = 1'b0;
      unique case (st_q)
         ST_CMD: if (rx_byte_vld) begin
            rc_clr = 1'b1;
            if (rx_byte == CMD_READ)        st_n = ST_READ;
            else if (rx_byte == CMD_MATCH)  st_n = ST_MATCH;
            else if (rx_byte == CMD_SEARCH) st_n = ST_SBIT;
            else if (rx_byte == CMD_SKIP) begin
               st_n = ST_DONE; sel_set = 1'b1;
            end else if (rx_byte == CMD_RESUME) begin
               rc_clr = 1'b0;
               if (rc_q) begin st_n = ST_DONE; sel_set = 1'b1; end
               else st_n = ST_DEAD;
            end else if (OD_EN && rx_byte == CMD_OD_SKIP) begin
               st_n = ST_DONE; sel_set = 1'b1; od_set = 1'b1;
            end else if (OD_EN && rx_byte == CMD_OD_MATCH) begin
               st_n = ST_MATCH; od_set = 1'b1;
            end else st_n = ST_DEAD;
         end
         ST_READ: if (tx_bit_done) begin
            if (idx_last) begin st_n = ST_DONE; sel_set = 1'b1; end
            else idx_inc = 1'b1;
         end
         ST_MATCH: if (rx_bit_vld) begin
            if (rx_bit != cur_bit) st_n = ST_DEAD;
            else if (idx_last) begin
               st_n = ST_DONE; sel_set = 1'b1; rc_set = 1'b1;
            end else idx_inc = 1'b1;
         end
         ST_SBIT: if (tx_bit_done) st_n = ST_SCMP;
         ST_SCMP: if (tx_bit_done) st_n = ST_SRX;
         ST_SRX: if (rx_bit_vld) begin
            if (rx_bit != cur_bit) st_n = ST_DEAD;
            else if (idx_last) begin
               st_n = ST_DONE; sel_set = 1'b1; rc_set = 1'b1;
            end else begin
               idx_inc = 1'b1; st_n = ST_SBIT;
            end
         end
         default: st_n = st_q;
      endcase
      if (bus_reset) begin
         st_n = ST_CMD; idx_inc = 1'b0; sel_set = 1'b0;
         rc_set = 1'b0; rc_clr = 1'b0; od_set = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_CMD;
         rc_q  <= 1'b0;
         sel_q <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         st_q <= st_n;
         go_q <= sel_set;
         if (bus_reset)    sel_q <= 1'b0;
         else if (sel_set) sel_q <= 1'b1;
         if (rc_set)       rc_q <= 1'b1;
         else if (rc_clr)  rc_q <= 1'b0;
      end
   end

   if (OD_EN) begin : g_od
      logic od_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          od_q <= 1'b0;
         else if (bus_reset && bus_reset_std) od_q <= 1'b0;
         else if (od_set)                     od_q <= 1'b1;
      end
      assign overdrive = od_q;
   end else begin : g_no_od
      logic unused_od;
      assign unused_od = od_set ^ bus_reset_std;
      assign overdrive = 1'b0;
   end

   assign rx_byte_req = (st_q == ST_CMD);
   assign rx_bit_req  = (st_q == ST_MATCH) || (st_q == ST_SRX);
   assign tx_bit_vld  = (st_q == ST_READ) || (st_q == ST_SBIT) || (st_q == ST_SCMP);
   assign tx_bit      = (st_q == ST_SCMP) ? ~cur_bit : cur_bit;
   assign selected    = sel_q;
   assign mem_go      = go_q;
endmodule

// File: rtl/rom_select_engine_chk.sv
module rom_select_engine_chk #(
   parameter bit OD_EN = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_reset,
   input logic       bus_reset_std,
   input logic       rx_byte_vld,
   input logic [7:0] rx_byte,
   input logic       tx_bit_vld,
   input logic       rx_bit_req,
   input logic       rx_byte_req,
   input logic       selected,
   input logic       overdrive,
   input logic       mem_go
);
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_bit_vld, rx_bit_req, rx_byte_req})); // R11
   AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> !(tx_bit_vld || rx_bit_req || rx_byte_req)); // R11
   AST_GO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_go |-> selected && !$past(selected)); // R9
   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !selected && rx_byte_req); // R8
   AST_STD_RESET_OD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset && bus_reset_std |=> !overdrive); // R7
   AST_SHORT_RESET_OD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset && !bus_reset_std && overdrive |=> overdrive); // R7
   AST_SKIP_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_req && rx_byte_vld && rx_byte == 8'hCC && !bus_reset |=> selected); // R5
   AST_ODSKIP_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
      OD_EN && rx_byte_req && rx_byte_vld && rx_byte == 8'h3C && !bus_reset |=> overdrive); // R7
endmodule

bind rom_select_engine rom_select_engine_chk #(.OD_EN(OD_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bus_reset_std(bus_reset_std),
   .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .tx_bit_vld(tx_bit_vld),
   .rx_bit_req(rx_bit_req), .rx_byte_req(rx_byte_req), .selected(selected),
   .overdrive(overdrive), .mem_go(mem_go)
);

// File: tb/tb_rom_select_engine.sv
module tb_rom_select_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0, bus_reset_std = 1'b0;
   logic rx_byte_vld = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic rx_bit_vld = 1'b0, rx_bit = 1'b0, tx_bit_done = 1'b0;
   logic tx_bit_vld, tx_bit, rx_bit_req, rx_byte_req, selected, overdrive, mem_go;

   always #10 clk = ~clk;

   rom_select_engine dut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bus_reset_std(bus_reset_std),
      .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_bit_vld(rx_bit_vld),
      .rx_bit(rx_bit), .tx_bit_done(tx_bit_done), .tx_bit_vld(tx_bit_vld),
      .tx_bit(tx_bit), .rx_bit_req(rx_bit_req), .rx_byte_req(rx_byte_req),
      .selected(selected), .overdrive(overdrive), .mem_go(mem_go)
   );

   // identity built from the requirement text
   logic [63:0] id_ref;
   initial begin
      logic [55:0] body;
      logic [7:0] c;
      body = {48'h00A1B2C3D4E5, 8'h2D};
      c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         logic f;
         f = c[0] ^ body[i];
         c = c >> 1;
         if (f) c = c ^ 8'h8C;
      end
      id_ref = {c, body};
   end

   // reference model: 0 cmd,1 read,2 match,3 search bit,4 search cmp,5 search rx,6 done,7 dead
   int m_st = 0, m_idx = 0;
   bit m_sel = 0, m_od = 0, m_rc = 0, m_go = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_sel = 0; m_od = 0; m_rc = 0; m_go = 0;
      end else begin
         m_go = 0;
         if (bus_reset) begin
            m_st = 0; m_idx = 0; m_sel = 0;
            if (bus_reset_std) m_od = 0;
         end else begin
            case (m_st)
               0: if (rx_byte_vld) begin
                  case (rx_byte)
                     8'h33: begin m_st = 1; m_rc = 0; end
                     8'h55: begin m_st = 2; m_rc = 0; end
                     8'h69: begin m_st = 2; m_rc = 0; m_od = 1; end
                     8'hF0: begin m_st = 3; m_rc = 0; end
                     8'hCC: begin m_st = 6; m_rc = 0; m_sel = 1; m_go = 1; end
                     8'h3C: begin m_st = 6; m_rc = 0; m_sel = 1; m_go = 1; m_od = 1; end
                     8'hA5: if (m_rc) begin m_st = 6; m_sel = 1; m_go = 1; end else m_st = 7;
                     default: begin m_st = 7; m_rc = 0; end
                  endcase
               end
               1: if (tx_bit_done) begin
                  if (m_idx == 63) begin m_st = 6; m_sel = 1; m_go = 1; end
                  else m_idx++;
               end
               2, 5: if (rx_bit_vld) begin
                  if (rx_bit != id_ref[m_idx]) m_st = 7;
                  else if (m_idx == 63) begin m_st = 6; m_sel = 1; m_go = 1; m_rc = 1; end
                  else begin m_idx++; if (m_st == 5) m_st = 3; end
               end
               3: if (tx_bit_done) m_st = 4;
               4: if (tx_bit_done) m_st = 5;
               default: ;
            endcase
         end
      end
   end

   int n_cmp = 0, n_bad = 0, cyc = 0;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_txv;
         e_txv = (m_st == 1 || m_st == 3 || m_st == 4);
         chk(rx_byte_req == (m_st == 0), cur_req, "rx_byte_req R1", rx_byte_req, m_st == 0);
         chk(rx_bit_req == (m_st == 2 || m_st == 5), cur_req, "rx_bit_req R11", rx_bit_req, m_st == 2 || m_st == 5);
         chk(tx_bit_vld == e_txv, cur_req, "tx_bit_vld R11", tx_bit_vld, e_txv);
         if (e_txv) chk(tx_bit == (id_ref[m_idx] ^ (m_st == 4)), cur_req, "tx_bit R2", tx_bit, id_ref[m_idx] ^ (m_st == 4));
         chk(selected == m_sel, cur_req, "selected", selected, m_sel);
         chk(overdrive == m_od, cur_req, "overdrive R7", overdrive, m_od);
         chk(mem_go == m_go, cur_req, "mem_go R9", mem_go, m_go);
      end
   end

   task automatic send_cmd(input logic [7:0] b);
      @(negedge clk); rx_byte = b; rx_byte_vld = 1'b1;
      @(negedge clk); rx_byte_vld = 1'b0;
   endtask
   task automatic send_bit(input logic b);
      @(negedge clk); rx_bit = b; rx_bit_vld = 1'b1;
      @(negedge clk); rx_bit_vld = 1'b0;
   endtask
   task automatic tx_done();
      @(negedge clk); tx_bit_done = 1'b1;
      @(negedge clk); tx_bit_done = 1'b0;
   endtask
   task automatic breset(input logic std);
      @(negedge clk); bus_reset = 1'b1; bus_reset_std = std;
      @(negedge clk); bus_reset = 1'b0; bus_reset_std = 1'b0;
   endtask
   task automatic do_match(input int bad);
      for (int i = 0; i < 64; i++) send_bit(i == bad ? ~id_ref[i] : id_ref[i]);
   endtask
   task automatic do_search(input int bad);
      for (int i = 0; i < 64; i++) begin
         tx_done(); tx_done();
         send_bit(i == bad ? ~id_ref[i] : id_ref[i]);
         if (i == bad) begin tx_done(); break; end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1"; repeat (3) @(negedge clk);
      chk(rx_byte_req && !selected && !mem_go, "R1", "idle after reset", rx_byte_req, 1);

      cur_req = "R2"; send_cmd(8'h33);
      for (int i = 0; i < 64; i++) tx_done();
      @(negedge clk);
      chk(selected, "R2", "selected after read", selected, 1);

      cur_req = "R8"; breset(1'b1);
      chk(!selected && rx_byte_req, "R8", "reset deselects", selected, 0);

      cur_req = "R3"; send_cmd(8'h55); do_match(-1);
      chk(selected, "R3", "match selects", selected, 1);
      cur_req = "R6"; breset(1'b1); send_cmd(8'hA5);
      chk(selected, "R6", "resume after match", selected, 1);
      breset(1'b0); send_cmd(8'hA5);
      chk(selected, "R6", "resume repeats", selected, 1);
      cur_req = "R5"; breset(1'b1); send_cmd(8'hCC);
      chk(selected, "R5", "skip selects", selected, 1);
      cur_req = "R6"; breset(1'b1); send_cmd(8'hA5);
      chk(!selected && !rx_byte_req, "R6", "resume after skip silent", selected, 0);

      cur_req = "R3"; breset(1'b1); send_cmd(8'h55); do_match(10);
      chk(!selected && !rx_bit_req, "R3", "mismatch drops", selected, 0);
      cur_req = "R6"; breset(1'b1); send_cmd(8'hA5);
      chk(!selected, "R6", "resume after failed match", selected, 0);

      cur_req = "R4"; breset(1'b1); send_cmd(8'hF0); do_search(-1);
      chk(selected, "R4", "search selects", selected, 1);
      cur_req = "R6"; breset(1'b1); send_cmd(8'hA5);
      chk(selected, "R6", "resume after search", selected, 1);
      cur_req = "R4"; breset(1'b1); send_cmd(8'hF0); do_search(5);
      chk(!selected && !tx_bit_vld, "R4", "search drop-out", selected, 0);
      breset(1'b1); send_cmd(8'hF0); do_search(63);
      chk(!selected, "R4", "search drop at last bit", selected, 0);

      cur_req = "R7"; breset(1'b1); send_cmd(8'h3C);
      chk(overdrive && selected, "R7", "overdrive skip", overdrive, 1);
      breset(1'b0);
      chk(overdrive, "R7", "short reset keeps speed", overdrive, 1);
      breset(1'b1);
      chk(!overdrive, "R7", "standard reset clears speed", overdrive, 0);
      send_cmd(8'h69); do_match(-1);
      chk(overdrive && selected, "R7", "overdrive match", overdrive, 1);
      breset(1'b1);

      cur_req = "R10"; send_cmd(8'h12); send_bit(1'b1); tx_done();
      chk(!selected && !rx_byte_req, "R10", "unknown code silent", selected, 0);
      breset(1'b1); send_cmd(8'hA5);
      chk(!selected, "R10", "unknown clears resume", selected, 0);

      cur_req = "R8"; breset(1'b1); send_cmd(8'h33);
      for (int i = 0; i < 20; i++) tx_done();
      breset(1'b1);
      chk(rx_byte_req && !tx_bit_vld, "R8", "reset mid-read", rx_byte_req, 1);
      send_cmd(8'h33);
      chk(tx_bit_vld && tx_bit == id_ref[0], "R2", "read restarts at bit 0", tx_bit, id_ref[0]);
      breset(1'b1);
      repeat (3) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule